// File: doc/BRIEF.md
# Oscillator Trim Register Slave on I2C

This block is a two-wire serial slave that owns the small register space of an oscillator trim controller. It watches the SCL and SDA bus lines on a fast system clock and answers to a fixed 7-bit address. It pulls SDA low through an open-drain enable for its acknowledge slots and for the data bits it returns. A master writes a word address to set a two-bit register pointer, then writes or reads any number of bytes. The pointer steps after every byte and keeps its value from one transfer to the next.

Two registers hold a 15-bit two's-complement frequency tuning word plus a bit that freezes compensation updates. These drive the trim controller directly, and a one-cycle strobe marks each write of the low tuning byte. Two more registers show a 12-bit temperature code. That code is a snapshot of the live sensor value, taken only when a write-addressed transfer delivers its word address. A multi-byte read therefore always returns the upper and lower temperature fields from the same sample.

Top module: `osc_trim_i2c_slave`

## Requirements
- R1: The slave acknowledges an address byte whose upper seven bits equal 7'b1000001, and takes bit 0 as direction (0 write, 1 read). Any other address gets no acknowledge, and the slave ignores the bus until the next START or STOP.
- R2: In a write, the first byte after the address loads the pointer from its two low bits. Every later byte is written to the register at the pointer, after which the pointer increments, wrapping from 3 to 0. All of these bytes are acknowledged.
- R3: A read returns bytes MSB first, starting at the current pointer, and increments the pointer after each byte. It continues while the master acknowledges and releases SDA after a master NACK. When a read is not preceded by a word address, it resumes from the pointer value left by the previous transfer.
- R4: Register 0 bit 7 drives comp_hold_o, and register 0 bits 6..0 drive tune_word_o[14:8]. Register 1 drives tune_word_o[7:0]. Both registers reset to 0.
- R5: tune_updated_o pulses for exactly one clock for each completed write to register 1 and never for writes to any other register. tune_word_o[7:0] changes only in a cycle where tune_updated_o is high.
- R6: Data written to registers 2 and 3 is acknowledged and discarded. It changes neither the readback nor any output.
- R7: Register 2 reads snapshot bits 11..4. Register 3 reads snapshot bits 3..0 in its upper nibble, with zeros in its lower nibble. The snapshot resets to 0x190 and copies temp_live_i only when a word address byte is received after a write address. Reads never refresh it.
- R8: A START or repeated START, in any state including the middle of a byte, restarts address reception without writing the partial byte. A STOP returns the slave to idle with SDA released.
- R9: sda_pull_o becomes active only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 20 times the SCL rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Level of the SCL bus line |
| sda_i | input | 1 | Level of the SDA bus line |
| sda_pull_o | output | 1 | High to pull SDA low |
| temp_live_i | input | 12 | Live temperature code, 1/16 degree per LSB |
| tune_word_o | output | 15 | Two's-complement frequency tuning word |
| comp_hold_o | output | 1 | Freeze compensation updates |
| tune_updated_o | output | 1 | One-cycle strobe on a write to register 1 |

## Verification
The hardest case is a START that arrives in the middle of a data byte. The slave must not write the partial byte, and its pointer must stay where the word address put it. The stimulus sends a word address, clocks four bits of a data byte and issues a repeated START with a read. It then expects the unchanged register contents at the unchanged pointer. Snapshot coherence is reached by changing temp_live_i between transfers. A read with no word address must return the old sample, and a write of a word address must pick up the new one.

// File: rtl/osc_trim_pkg.sv
package osc_trim_pkg;
  localparam int unsigned TUNE_W = 15;
  localparam int unsigned TEMP_W = 12;
  localparam int unsigned REG_AW = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK
  } slv_state_e;

  typedef enum logic [1:0] {
    PH_DEV,
    PH_WORD,
    PH_DATA
  } rx_phase_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  // STAGES synchronizer flops plus one history flop per line
  logic [STAGES:0] scl_sh, sda_sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sh <= '1;
      sda_sh <= '1;
    end else begin
      scl_sh <= {scl_sh[STAGES-1:0], scl_i};
      sda_sh <= {sda_sh[STAGES-1:0], sda_i};
    end
  end

  logic scl_c, scl_p, sda_c, sda_p;
  assign scl_c = scl_sh[STAGES-1];
  assign scl_p = scl_sh[STAGES];
  assign sda_c = sda_sh[STAGES-1];
  assign sda_p = sda_sh[STAGES];

  assign sda_o      = sda_c;
  assign scl_rise_o = scl_c & ~scl_p;
  assign scl_fall_o = ~scl_c & scl_p;
  assign start_o    = scl_c & scl_p & sda_p & ~sda_c;
  assign stop_o     = scl_c & scl_p & ~sda_p & sda_c;
endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
  import osc_trim_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h41
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [7:0]        rd_data_i,
  output logic [REG_AW-1:0] ptr_o,
  output logic              wr_en_o,
  output logic [REG_AW-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic              snap_load_o,
  output logic              sda_pull_o
);
  slv_state_e        state;
  rx_phase_e         phase;
  logic [3:0]        bit_cnt;
  logic [7:0]        shreg;
  logic [REG_AW-1:0] ptr;
  logic              rd_mode, mack, pull;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state       <= ST_IDLE;
      phase       <= PH_DEV;
      bit_cnt     <= '0;
      shreg       <= '0;
      ptr         <= '0;
      rd_mode     <= 1'b0;
      mack        <= 1'b0;
      pull        <= 1'b0;
      wr_en_o     <= 1'b0;
      wr_addr_o   <= '0;
      wr_data_o   <= '0;
      snap_load_o <= 1'b0;
    end else begin
      wr_en_o     <= 1'b0;
      snap_load_o <= 1'b0;
      if (start_i) begin
        state   <= ST_RX;
        phase   <= PH_DEV;
        bit_cnt <= '0;
        pull    <= 1'b0;
      end else if (stop_i) begin
        state <= ST_IDLE;
        pull  <= 1'b0;
      end else begin
        case (state)
          ST_RX: begin
            if (scl_rise_i && bit_cnt != 4'd8) begin
              shreg   <= {shreg[6:0], sda_i};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall_i && bit_cnt == 4'd8) begin
              bit_cnt <= '0;
              case (phase)
                PH_DEV: begin
                  if (shreg[7:1] == DEV_ADDR) begin
                    rd_mode <= shreg[0];
                    pull    <= 1'b1;
                    state   <= ST_RX_ACK;
                  end else begin
                    state <= ST_IDLE;
                  end
                end
                PH_WORD: begin
                  ptr         <= shreg[REG_AW-1:0];
                  snap_load_o <= 1'b1;
                  pull        <= 1'b1;
                  state       <= ST_RX_ACK;
                end
                default: begin
                  wr_en_o   <= 1'b1;
                  wr_addr_o <= ptr;
                  wr_data_o <= shreg;
                  ptr       <= ptr + 1'b1;
                  pull      <= 1'b1;
                  state     <= ST_RX_ACK;
                end
              endcase
            end
          end
          ST_RX_ACK: begin
            if (scl_fall_i) begin
              if (phase == PH_DEV && rd_mode) begin
                state <= ST_TX;
                shreg <= rd_data_i;
                pull  <= ~rd_data_i[7];
              end else begin
                pull  <= 1'b0;
                state <= ST_RX;
                phase <= (phase == PH_DEV) ? PH_WORD : PH_DATA;
              end
            end
          end
          ST_TX: begin
            if (scl_rise_i) begin
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall_i) begin
              if (bit_cnt == 4'd8) begin
                pull    <= 1'b0;
                bit_cnt <= '0;
                ptr     <= ptr + 1'b1;
                state   <= ST_TX_ACK;
              end else begin
                shreg <= {shreg[6:0], 1'b0};
                pull  <= ~shreg[6];
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise_i) begin
              mack <= ~sda_i;
            end else if (scl_fall_i) begin
              if (mack) begin
                state <= ST_TX;
                shreg <= rd_data_i;
                pull  <= ~rd_data_i[7];
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign ptr_o      = ptr;
  assign sda_pull_o = pull;
endmodule

// File: rtl/trim_regfile.sv
module trim_regfile
  import osc_trim_pkg::*;
#(
  parameter logic [TEMP_W-1:0] TEMP_RESET = 12'h190
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [REG_AW-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic [REG_AW-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o,
  input  logic              snap_load_i,
  input  logic [TEMP_W-1:0] temp_live_i,
  output logic [TEMP_W-1:0] temp_snap_o,
  output logic [TUNE_W-1:0] tune_word_o,
  output logic              comp_hold_o,
  output logic              tune_updated_o
);
  localparam int unsigned LO_W = TEMP_W - 8;

  logic [7:0]        tune_hi, tune_lo;
  logic [TEMP_W-1:0] snap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tune_hi        <= '0;
      tune_lo        <= '0;
      snap           <= TEMP_RESET;
      tune_updated_o <= 1'b0;
    end else begin
      tune_updated_o <= wr_en_i && (wr_addr_i == 2'd1);
      if (wr_en_i && wr_addr_i == 2'd0) tune_hi <= wr_data_i;
      if (wr_en_i && wr_addr_i == 2'd1) tune_lo <= wr_data_i;
      if (snap_load_i) snap <= temp_live_i;
    end
  end

  always_comb begin
    case (rd_addr_i)
      2'd0:    rd_data_o = tune_hi;
      2'd1:    rd_data_o = tune_lo;
      2'd2:    rd_data_o = snap[TEMP_W-1:LO_W];
      default: rd_data_o = {snap[LO_W-1:0], {(8-LO_W){1'b0}}};
    endcase
  end

  assign tune_word_o = {tune_hi[6:0], tune_lo};
  assign comp_hold_o = tune_hi[7];
  assign temp_snap_o = snap;
endmodule

// File: rtl/osc_trim_i2c_slave.sv
module osc_trim_i2c_slave
  import osc_trim_pkg::*;
#(
  parameter logic [6:0]        DEV_ADDR    = 7'h41,
  parameter int unsigned       SYNC_STAGES = 2,
  parameter logic [TEMP_W-1:0] TEMP_RESET  = 12'h190
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull_o,
  input  logic [TEMP_W-1:0] temp_live_i,
  output logic [TUNE_W-1:0] tune_word_o,
  output logic              comp_hold_o,
  output logic              tune_updated_o
);
  logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [REG_AW-1:0] ptr, wr_addr;
  logic [7:0]        rd_data, wr_data;
  logic              wr_en, snap_load;
  logic [TEMP_W-1:0] temp_snap;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  i2c_slave_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sda_i       (sda_s),
    .scl_rise_i  (scl_rise),
    .scl_fall_i  (scl_fall),
    .start_i     (start_det),
    .stop_i      (stop_det),
    .rd_data_i   (rd_data),
    .ptr_o       (ptr),
    .wr_en_o     (wr_en),
    .wr_addr_o   (wr_addr),
    .wr_data_o   (wr_data),
    .snap_load_o (snap_load),
    .sda_pull_o  (sda_pull_o)
  );

  trim_regfile #(.TEMP_RESET(TEMP_RESET)) u_regs (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .wr_en_i        (wr_en),
    .wr_addr_i      (wr_addr),
    .wr_data_i      (wr_data),
    .rd_addr_i      (ptr),
    .rd_data_o      (rd_data),
    .snap_load_i    (snap_load),
    .temp_live_i    (temp_live_i),
    .temp_snap_o    (temp_snap),
    .tune_word_o    (tune_word_o),
    .comp_hold_o    (comp_hold_o),
    .tune_updated_o (tune_updated_o)
  );
endmodule

// File: rtl/osc_trim_i2c_checker.sv
module osc_trim_i2c_checker
  import osc_trim_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              scl_i,
  input logic              sda_pull_o,
  input logic [TUNE_W-1:0] tune_word_o,
  input logic              tune_updated_o,
  input logic              stop_det,
  input logic              snap_load,
  input logic [TEMP_W-1:0] temp_snap
);
  p_strobe_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tune_updated_o |=> !tune_updated_o);

  p_low_byte_strobed_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $changed(tune_word_o[7:0]) |-> tune_updated_o);

  p_pull_while_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_pull_o) |-> !scl_i);

  p_stop_releases_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> !sda_pull_o);

  p_snap_on_word_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $changed(temp_snap) |-> $past(snap_load));
endmodule

bind osc_trim_i2c_slave osc_trim_i2c_checker u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .scl_i          (scl_i),
  .sda_pull_o     (sda_pull_o),
  .tune_word_o    (tune_word_o),
  .tune_updated_o (tune_updated_o),
  .stop_det       (stop_det),
  .snap_load      (snap_load),
  .temp_snap      (temp_snap)
);

// File: tb/osc_trim_i2c_slave_tb_top.sv
module osc_trim_i2c_slave_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic [11:0] temp_live = 12'h000;
  logic        sda_pull;
  logic [14:0] tune_word;
  logic        comp_hold;
  logic        tune_upd;
  wire         sda_line = sda_m & ~sda_pull;

  int n_checks = 0;
  int n_fail   = 0;
  int strobe_cnt = 0;
  int strobe_long = 0;
  logic strobe_prev = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] act_q[$];

  always #2ns clk = ~clk;

  osc_trim_i2c_slave dut_i (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .scl_i          (scl_m),
    .sda_i          (sda_line),
    .sda_pull_o     (sda_pull),
    .temp_live_i    (temp_live),
    .tune_word_o    (tune_word),
    .comp_hold_o    (comp_hold),
    .tune_updated_o (tune_upd)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // strobe monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (tune_upd) strobe_cnt++;
      if (tune_upd && strobe_prev) strobe_long++;
    end
    strobe_prev <= tune_upd;
  end

  // scoreboard monitor: pops read bytes as they appear
  always @(negedge clk) begin
    if (act_q.size() != 0) begin
      logic [7:0] a, e;
      string t;
      a = act_q.pop_front();
      if (exp_q.size() != 0) begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(a == e, t, a, e);
      end else begin
        check(1'b0, "R3 unexpected byte", a, 0);
      end
    end
  end

  task automatic expect_byte(input logic [7:0] v, input string t);
    exp_q.push_back(v);
    tag_q.push_back(t);
  endtask

  task automatic qwait();
    #60ns;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; qwait();
    scl_m = 1'b1; qwait();
    sda_m = 1'b0; qwait();
    scl_m = 1'b0; qwait();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qwait();
    scl_m = 1'b1; qwait();
    sda_m = 1'b1; qwait();
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; qwait();
    scl_m = 1'b1; qwait(); qwait();
    scl_m = 1'b0; qwait();
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; qwait();
    scl_m = 1'b1; qwait();
    b = sda_line; qwait();
    scl_m = 1'b0; qwait();
  endtask

  task automatic send_byte(input logic [7:0] v, output logic acked);
    logic ab;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(ab);
    acked = ~ab;
  endtask

  task automatic recv_byte(input logic give_ack);
    logic [7:0] v;
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    act_q.push_back(v);
    put_bit(~give_ack);
  endtask

  task automatic read_n(input int n);
    for (int i = 0; i < n; i++) recv_byte(i < n - 1);
  endtask

  task automatic send_chk(input logic [7:0] v, input logic exp_ack, input string req);
    logic ak;
    send_byte(v, ak);
    check(ak == exp_ack, req, ak, exp_ack);
  endtask

  localparam logic [7:0] ADDR_W = 8'h82;
  localparam logic [7:0] ADDR_R = 8'h83;

  initial begin
    #600us;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // reset state (R4)
    check(tune_word == 15'h0, "R4 reset tune", tune_word, 0);
    check(comp_hold == 1'b0, "R4 reset hold", comp_hold, 0);
    check(sda_pull == 1'b0, "R9 reset pull", sda_pull, 0);

    temp_live = 12'h2A5;
    // read all four registers from reset pointer (R3, R7 reset 0x190)
    expect_byte(8'h00, "R3 reg0 reset");
    expect_byte(8'h00, "R3 reg1 reset");
    expect_byte(8'h19, "R7 reset temp hi");
    expect_byte(8'h00, "R7 reset temp lo");
    bus_start();
    send_chk(ADDR_R, 1'b1, "R1 read addr ack");
    read_n(4);
    check(sda_pull == 1'b0, "R3 release after nack", sda_pull, 0);
    bus_stop();

    // write tuning (R1, R2, R4, R5)
    bus_start();
    send_chk(ADDR_W, 1'b1, "R1 write addr ack");
    send_chk(8'h00, 1'b1, "R2 word ack");
    send_chk(8'h85, 1'b1, "R2 data0 ack");
    send_chk(8'h3C, 1'b1, "R2 data1 ack");
    bus_stop();
    repeat (4) @(negedge clk);
    check(tune_word == 15'h053C, "R4 tune word", tune_word, 15'h053C);
    check(comp_hold == 1'b1, "R4 hold bit", comp_hold, 1);
    check(strobe_cnt == 1, "R5 strobe count", strobe_cnt, 1);

    // resume read from persisted pointer 2 (R3, R7 snapshot 0x2A5)
    expect_byte(8'h2A, "R3 resume temp hi");
    expect_byte(8'h50, "R7 temp lo nibble");
    bus_start();
    send_chk(ADDR_R, 1'b1, "R1 read addr ack");
    read_n(2);
    bus_stop();

    // word address then repeated START read (R8, R7 refresh)
    temp_live = 12'h3FF;
    expect_byte(8'h3F, "R8 rstart temp hi");
    expect_byte(8'hF0, "R7 refreshed lo");
    bus_start();
    send_chk(ADDR_W, 1'b1, "R1 write addr ack");
    send_chk(8'h02, 1'b1, "R2 word ack");
    bus_start();
    send_chk(ADDR_R, 1'b1, "R8 rstart addr ack");
    read_n(2);
    bus_stop();

    // write at 3 ignored, wrap to 0 and 1 (R2, R6)
    bus_start();
    send_chk(ADDR_W, 1'b1, "R1 write addr ack");
    send_chk(8'h03, 1'b1, "R2 word ack");
    send_chk(8'hAA, 1'b1, "R6 ignored data ack");
    send_chk(8'h11, 1'b1, "R2 wrap data ack");
    send_chk(8'h22, 1'b1, "R2 data ack");
    bus_stop();
    repeat (4) @(negedge clk);
    check(tune_word == 15'h1122, "R2 wrap tune", tune_word, 15'h1122);
    check(comp_hold == 1'b0, "R4 hold cleared", comp_hold, 0);
    check(strobe_cnt == 2, "R5 strobe count", strobe_cnt, 2);

    temp_live = 12'h123;
    expect_byte(8'h12, "R7 temp hi");
    expect_byte(8'h30, "R6 reg3 not written");
    bus_start();
    send_chk(ADDR_W, 1'b1, "R1 write addr ack");
    send_chk(8'h02, 1'b1, "R2 word ack");
    bus_start();
    send_chk(ADDR_R, 1'b1, "R8 rstart addr ack");
    read_n(2);
    bus_stop();

    // foreign address ignored (R1)
    bus_start();
    send_chk(8'h84, 1'b0, "R1 foreign addr nack");
    send_chk(8'h00, 1'b0, "R1 ignored word");
    send_chk(8'h77, 1'b0, "R1 ignored data");
    bus_stop();
    repeat (4) @(negedge clk);
    check(tune_word == 15'h1122, "R1 tune unchanged", tune_word, 15'h1122);
    check(strobe_cnt == 2, "R1 no strobe", strobe_cnt, 2);

    // START in the middle of a data byte (R8)
    expect_byte(8'h22, "R8 partial byte dropped");
    bus_start();
    send_chk(ADDR_W, 1'b1, "R1 write addr ack");
    send_chk(8'h01, 1'b1, "R2 word ack");
    for (int i = 0; i < 4; i++) put_bit(1'b1);
    bus_start();
    send_chk(ADDR_R, 1'b1, "R8 restart addr ack");
    read_n(1);
    bus_stop();
    repeat (4) @(negedge clk);
    check(strobe_cnt == 2, "R8 no strobe on partial", strobe_cnt, 2);
    check(sda_pull == 1'b0, "R8 idle after stop", sda_pull, 0);

    // write to register 0 only: no strobe (R5)
    bus_start();
    send_chk(ADDR_W, 1'b1, "R1 write addr ack");
    send_chk(8'h00, 1'b1, "R2 word ack");
    send_chk(8'h7F, 1'b1, "R2 data ack");
    bus_stop();
    repeat (4) @(negedge clk);
    check(tune_word == 15'h7F22, "R4 high bits", tune_word, 15'h7F22);
    check(strobe_cnt == 2, "R5 no strobe for reg0", strobe_cnt, 2);

    // read without word address: snapshot not refreshed by read (R3, R7)
    temp_live = 12'h0AB;
    expect_byte(8'h22, "R3 resume reg1");
    expect_byte(8'h12, "R7 read keeps snap hi");
    expect_byte(8'h30, "R7 read keeps snap lo");
    bus_start();
    send_chk(ADDR_R, 1'b1, "R1 read addr ack");
    read_n(3);
    bus_stop();

    repeat (10) @(negedge clk);
    check(strobe_long == 0, "R5 strobe width", strobe_long, 0);
    check(exp_q.size() == 0, "R3 missing bytes", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule